// File: doc/BRIEF.md
# Operand Effective Address Unit

This block turns a decoded addressing mode into the 32-bit memory address of an operand. Each request carries a mode code, an access size, the value of the selected pointer register, the immediate field of the instruction and a flag marking a program-address access. One pipeline register captures the request. The address, a misalignment flag and the pointer update for the register file are then derived combinationally from that captured request.

Requests travel over a valid/ready stream. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. The result is offered with `out_valid` and is held unchanged until `out_ready` is seen high on a rising edge. The pointer write strobe `wb_en` rises only in the cycle of that output handshake. The register file therefore commits `wb_value` exactly once, on the edge that retires the request.

Top module: `eag_unit`

## Requirements
- R1: Mode code 0 (register indirect) gives the pointer value as the address when the program flag is low.
- R2: In mode 0 with the program flag high, address bits 31:24 are zero and bits 23:0 come from the pointer.
- R3: Mode 1 adds the sign-extended low 16 bits of the immediate to the pointer. Mode 2 adds the full 32-bit immediate.
- R4: Mode 3 (post-increment) uses the pointer as the address and writes back pointer + step. The step is 1 for size code 0 (byte), 2 for size 1 (word) and 4 for size 2 (long).
- R5: Mode 4 (pre-decrement) uses pointer − step as the address and writes back that same value.
- R6: Mode 5 gives ones in bits 31:8 above immediate bits 7:0. Mode 6 sign-extends immediate bits 15:0. Immediate bits above the used field have no effect.
- R7: Mode 7 gives zero in bits 31:24 above immediate bits 23:0. Mode 8 passes the immediate through unchanged, whatever the program flag.
- R8: All address and pointer arithmetic wraps modulo 2^32.
- R9: `out_misalign` is high exactly when the size is not byte and address bit 0 is 1. The address is still presented unchanged.
- R10: `wb_en` is high only for modes 3 and 4, and only in a cycle where `out_valid` and `out_ready` are both high.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value.
- R12: After reset, `out_valid` and `wb_en` are low and `in_ready` is high.
- R13: Size code 3 behaves as long. Mode codes 9 to 15 give the pointer as the address and never write back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request slot free |
| in_mode | input | 4 | Addressing mode code |
| in_size | input | 2 | Access size code |
| in_prog | input | 1 | Program-address access flag |
| in_base | input | 32 | Selected pointer register value |
| in_imm | input | 32 | Displacement or absolute field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_ea | output | 32 | Effective address |
| out_misalign | output | 1 | Odd address on word or long access |
| wb_en | output | 1 | Pointer write strobe |
| wb_value | output | 32 | New pointer value |

## Verification
The address, the misalignment flag and `wb_value` are due in the cycle after the rising edge that accepts a request. That is one register from input to output. The bench samples them at the falling edge that follows that edge. `wb_en` depends on `out_ready` combinationally. It is therefore checked at the same falling edge with `out_ready` already driven, both high and low. The back-pressure test checks the outputs again after a whole stalled cycle, then after release, so that each observation falls inside a known cycle.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    AM_IND    = 4'd0,
    AM_DISP16 = 4'd1,
    AM_DISP32 = 4'd2,
    AM_POSTINC = 4'd3,
    AM_PREDEC = 4'd4,
    AM_ABS8   = 4'd5,
    AM_ABS16  = 4'd6,
    AM_ABS24  = 4'd7,
    AM_ABS32  = 4'd8
  } eag_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LONG_ALT = 2'd3
  } eag_size_e;

  localparam int MODE_W = 4;
  localparam int SIZE_W = 2;
endpackage

// File: rtl/eag_pipe_reg.sv
module eag_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R11
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R11
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
  import eag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PROG_W  = 24,
  parameter int SHORT_W = 8,
  parameter int HALF_W  = 16
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [SIZE_W-1:0] size,
  input  logic              prog,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] imm,
  output logic [ADDR_W-1:0] ea,
  output logic              step_en,
  output logic [ADDR_W-1:0] next_ptr
);
  localparam int PROG_PAD  = ADDR_W - PROG_W;
  localparam int SHORT_PAD = ADDR_W - SHORT_W;
  localparam int HALF_PAD  = ADDR_W - HALF_W;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] half_sext;
  logic [ADDR_W-1:0] dec_ptr;

  always_comb begin
    unique case (size)
      SZ_BYTE: step = ADDR_W'(1);
      SZ_WORD: step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
  end

  assign half_sext = {{HALF_PAD{imm[HALF_W-1]}}, imm[HALF_W-1:0]};
  assign dec_ptr   = base - step;

  always_comb begin
    ea       = base;
    step_en  = 1'b0;
    next_ptr = base;
    case (mode)
      AM_IND:     ea = prog ? {{PROG_PAD{1'b0}}, base[PROG_W-1:0]} : base;
      AM_DISP16:  ea = base + half_sext;
      AM_DISP32:  ea = base + imm;
      AM_POSTINC: begin
        ea       = base;
        step_en  = 1'b1;
        next_ptr = base + step;
      end
      AM_PREDEC: begin
        ea       = dec_ptr;
        step_en  = 1'b1;
        next_ptr = dec_ptr;
      end
      AM_ABS8:    ea = {{SHORT_PAD{1'b1}}, imm[SHORT_W-1:0]};
      AM_ABS16:   ea = half_sext;
      AM_ABS24:   ea = {{PROG_PAD{1'b0}}, imm[PROG_W-1:0]};
      AM_ABS32:   ea = imm;
      default:    ea = base;
    endcase
  end
endmodule

// File: rtl/eag_align_chk.sv
module eag_align_chk
  import eag_pkg::*;
(
  input  logic [SIZE_W-1:0] size,
  input  logic              ea_lsb,
  output logic              misalign
);
  assign misalign = (size != SZ_BYTE) && ea_lsb;
endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PROG_W  = 24,
  parameter int SHORT_W = 8,
  parameter int HALF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [SIZE_W-1:0] in_size,
  input  logic              in_prog,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_ea,
  output logic              out_misalign,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value
);
  localparam int REQ_W = MODE_W + SIZE_W + 1 + 2 * ADDR_W;

  logic [REQ_W-1:0]  req_d, req_q;
  logic [MODE_W-1:0] q_mode;
  logic [SIZE_W-1:0] q_size;
  logic              q_prog;
  logic [ADDR_W-1:0] q_base, q_imm;
  logic              step_en;

  assign req_d = {in_mode, in_size, in_prog, in_base, in_imm};
  assign {q_mode, q_size, q_prog, q_base, q_imm} = req_q;

  eag_pipe_reg #(.W(REQ_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(req_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(req_q)
  );

  eag_addr_calc #(
    .ADDR_W(ADDR_W), .PROG_W(PROG_W), .SHORT_W(SHORT_W), .HALF_W(HALF_W)
  ) u_calc (
    .mode(q_mode), .size(q_size), .prog(q_prog), .base(q_base), .imm(q_imm),
    .ea(out_ea), .step_en(step_en), .next_ptr(wb_value)
  );

  eag_align_chk u_align (
    .size(q_size), .ea_lsb(out_ea[0]), .misalign(out_misalign)
  );

  assign wb_en = out_valid && out_ready && step_en;

  logic [ADDR_W-1:0] inc_gap;
  assign inc_gap = wb_value - out_ea;

  AST_WB_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (q_mode == AM_POSTINC || q_mode == AM_PREDEC) && out_valid && out_ready); // R10
  AST_PINC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_mode == AM_POSTINC |-> $countones(inc_gap) == 1 && inc_gap < ADDR_W'(8)); // R4
  AST_PDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_mode == AM_PREDEC |-> wb_value == out_ea && out_ea != q_base); // R5
  AST_ABS8_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_mode == AM_ABS8 |-> &out_ea[ADDR_W-1:SHORT_W]); // R6
  AST_ABS24_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_mode == AM_ABS24 |-> out_ea[ADDR_W-1:PROG_W] == '0); // R7
  AST_MISALIGN_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_misalign |-> out_ea[0] && q_size != SZ_BYTE); // R9
endmodule

// File: tb/eag_unit_test.sv
module eag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_mode = '0;
  logic [1:0]  in_size = '0;
  logic        in_prog = 1'b0;
  logic [31:0] in_base = '0, in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_ea;
  logic        out_misalign;
  logic        wb_en;
  logic [31:0] wb_value;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  eag_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_size(in_size), .in_prog(in_prog),
    .in_base(in_base), .in_imm(in_imm), .out_valid(out_valid),
    .out_ready(out_ready), .out_ea(out_ea), .out_misalign(out_misalign),
    .wb_en(wb_en), .wb_value(wb_value)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [1:0]  size;
    logic        prog;
    logic [31:0] base;
    logic [31:0] imm;
    logic [31:0] ea;
    logic        wb;
    logic [31:0] wbv;
    logic        mis;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 2'd2, 1'b0, 32'h12345678, 32'h0,        32'h12345678, 1'b0, 32'h0,        1'b0, 8'd1},  // R1
    '{4'd0, 2'd0, 1'b1, 32'hAB345679, 32'h0,        32'h00345679, 1'b0, 32'h0,        1'b0, 8'd2},  // R2
    '{4'd1, 2'd1, 1'b0, 32'h00001000, 32'h0000FFFE, 32'h00000FFE, 1'b0, 32'h0,        1'b0, 8'd3},  // R3
    '{4'd1, 2'd2, 1'b0, 32'h0,        32'h00008000, 32'hFFFF8000, 1'b0, 32'h0,        1'b0, 8'd3},  // R3
    '{4'd2, 2'd2, 1'b0, 32'h90000004, 32'h80000000, 32'h10000004, 1'b0, 32'h0,        1'b0, 8'd8},  // R8
    '{4'd3, 2'd0, 1'b0, 32'h00000200, 32'h0,        32'h00000200, 1'b1, 32'h00000201, 1'b0, 8'd4},  // R4
    '{4'd3, 2'd2, 1'b0, 32'hFFFFFFFC, 32'h0,        32'hFFFFFFFC, 1'b1, 32'h00000000, 1'b0, 8'd8},  // R8
    '{4'd4, 2'd1, 1'b0, 32'h00000100, 32'h0,        32'h000000FE, 1'b1, 32'h000000FE, 1'b0, 8'd5},  // R5
    '{4'd4, 2'd2, 1'b0, 32'h0,        32'h0,        32'hFFFFFFFC, 1'b1, 32'hFFFFFFFC, 1'b0, 8'd8},  // R8
    '{4'd5, 2'd0, 1'b0, 32'h0,        32'h12345680, 32'hFFFFFF80, 1'b0, 32'h0,        1'b0, 8'd6},  // R6
    '{4'd6, 2'd1, 1'b0, 32'h0,        32'h00007FF0, 32'h00007FF0, 1'b0, 32'h0,        1'b0, 8'd6},  // R6
    '{4'd6, 2'd0, 1'b0, 32'h0,        32'h55558001, 32'hFFFF8001, 1'b0, 32'h0,        1'b0, 8'd6},  // R6
    '{4'd7, 2'd0, 1'b0, 32'h0,        32'hFF123456, 32'h00123456, 1'b0, 32'h0,        1'b0, 8'd7},  // R7
    '{4'd8, 2'd0, 1'b1, 32'h0,        32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 32'h0,        1'b0, 8'd7},  // R7
    '{4'd0, 2'd1, 1'b0, 32'h00000101, 32'h0,        32'h00000101, 1'b0, 32'h0,        1'b1, 8'd9},  // R9
    '{4'd3, 2'd2, 1'b0, 32'h00000103, 32'h0,        32'h00000103, 1'b1, 32'h00000107, 1'b1, 8'd9},  // R9
    '{4'd1, 2'd2, 1'b0, 32'h00000010, 32'h00000003, 32'h00000013, 1'b0, 32'h0,        1'b1, 8'd9},  // R9
    '{4'd1, 2'd0, 1'b0, 32'h00000010, 32'h00000003, 32'h00000013, 1'b0, 32'h0,        1'b0, 8'd9},  // R9
    '{4'd9, 2'd3, 1'b0, 32'h00000055, 32'h0,        32'h00000055, 1'b0, 32'h0,        1'b1, 8'd13}, // R13
    '{4'd3, 2'd3, 1'b0, 32'h00000010, 32'h0,        32'h00000010, 1'b1, 32'h00000014, 1'b0, 8'd13}  // R13
  };

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic [1:0] s, input logic p,
                       input logic [31:0] b, input logic [31:0] i);
    in_valid = 1'b1; in_mode = m; in_size = s; in_prog = p; in_base = b; in_imm = i;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check("out_valid in reset", 12, {31'b0, out_valid}, 32'd0);
    check("wb_en in reset", 12, {31'b0, wb_en}, 32'd0);
    check("in_ready in reset", 12, {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("out_valid after reset", 12, {31'b0, out_valid}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      out_ready = 1'b1;
      drive(VECS[k].mode, VECS[k].size, VECS[k].prog, VECS[k].base, VECS[k].imm);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check("out_valid", VECS[k].req, {31'b0, out_valid}, 32'd1);
      check("address", VECS[k].req, out_ea, VECS[k].ea);
      check("misalign", VECS[k].req, {31'b0, out_misalign}, {31'b0, VECS[k].mis});
      check("wb_en (R10)", VECS[k].req, {31'b0, wb_en}, {31'b0, VECS[k].wb});
      if (VECS[k].wb) check("wb_value", VECS[k].req, wb_value, VECS[k].wbv);
    end

    // R11 / R10: back-pressure holds result and withholds the write strobe
    @(negedge clk);
    out_ready = 1'b0;
    drive(4'd3, 2'd1, 1'b0, 32'h40, 32'h0);
    @(posedge clk);
    @(negedge clk);
    drive(4'd0, 2'd2, 1'b0, 32'h999, 32'h0);
    check("in_ready stalled", 11, {31'b0, in_ready}, 32'd0);
    check("wb_en stalled", 10, {31'b0, wb_en}, 32'd0);
    check("address stalled", 11, out_ea, 32'h40);
    @(posedge clk);
    @(negedge clk);
    check("out_valid held", 11, {31'b0, out_valid}, 32'd1);
    check("address held", 11, out_ea, 32'h40);
    out_ready = 1'b1;
    #1;
    check("wb_en on release", 10, {31'b0, wb_en}, 32'd1);
    check("wb_value on release", 4, wb_value, 32'h42);
    check("in_ready on release", 11, {31'b0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("next request address", 11, out_ea, 32'h999);
    check("next request wb_en", 10, {31'b0, wb_en}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("drained", 11, {31'b0, out_valid}, 32'd0);
    finish_run();
  end
endmodule